// File: doc/BRIEF.md
# Narrow-Width Value-Gated ALU

This block is a 32-bit integer ALU that looks at both operands of every operation as it arrives and decides whether the upper 16 bits of the datapath are needed at all. When both operands fit in a 16-bit lane, only the lower lane computes. The upper half of the result is rebuilt by extension, and the upper lane's inputs stay frozen at their last values so that its logic does not toggle. Arithmetic operations and the signed compare use a sign-extension test. The bitwise operations use a zero-extension test.

A narrow add or subtract whose 16-bit result leaves the signed 16-bit range cannot be rebuilt by extension. The block then holds the operands, raises a busy flag for one cycle and runs the operation again with both lanes enabled. A packing mode treats the datapath as two independent 16-bit lanes. The lower lane takes the low halves of the main operands and the main opcode. The upper lane takes a second, narrow operation. No carry crosses between the lanes. Each completed result comes with a flag telling whether the upper lane was used, so power can be accounted cycle by cycle.

Top module: `narrow_gate_alu`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid`, `busy`, `narrow` and `upper_en` are 0 and `result` is zero.
- R2: An operation accepted with `in_valid` high and `busy` low, and not reissued, appears with `out_valid` high in the next cycle. Its `result` equals the full 32-bit result for the opcode: 0 ADD and 1 SUB (both modulo 2^32), 2 AND, 3 OR, 4 XOR, 5 SLT (1 when A < B as signed numbers, else 0).
- R3: Opcodes 6 and 7 give a zero result. For the narrow test they behave like the arithmetic opcodes.
- R4: An operation runs narrow when both operands pass the opcode's narrow test. For ADD, SUB, SLT and opcodes 6 and 7, bits 31:15 of the operand must all be equal. For AND, OR and XOR, bits 31:16 must be zero. A narrow result reports `narrow`=1 and `upper_en`=0. A non-narrow result reports `narrow`=0 and `upper_en`=1.
- R5: A narrow ADD or SUB whose exact 16-bit signed result lies outside -32768..32767 gives `busy`=1 and `out_valid`=0 in the next cycle. In the cycle after that, `out_valid`=1, `narrow`=0, `upper_en`=1 and `result` is the correct 32-bit result.
- R6: An operation presented while `busy` is 1 is dropped and never produces a result.
- R7: With `pack_en`=1, bits 15:0 of `result` hold the lower-lane result (op_a[15:0], op_b[15:0], `opcode`). Bits 31:16 hold the upper-lane result (`pk_a`, `pk_b`, `pk_opcode`). Each lane wraps modulo 2^16, and a lane SLT gives 0 or 1 in its lane. No carry passes from the lower lane to the upper lane. op_a[31:16] and op_b[31:16] have no effect. The result reports `narrow`=0 and `upper_en`=1.
- R8: In a cycle that follows no accepted operation and no reissue, `out_valid` and `upper_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 3 | Main operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| pack_en | input | 1 | Run two 16-bit operations side by side |
| pk_opcode | input | 3 | Operation code of the upper lane in packing mode |
| pk_a | input | 16 | Upper-lane first operand in packing mode |
| pk_b | input | 16 | Upper-lane second operand in packing mode |
| out_valid | output | 1 | Result valid this cycle |
| result | output | 32 | Result, or two lane results when packed |
| narrow | output | 1 | Result was computed with the upper lane gated |
| upper_en | output | 1 | Upper lane evaluated for this result |
| busy | output | 1 | Overflow reissue in progress; inputs are ignored |

## Verification
The bench goes after the point where the two narrow tests diverge. A small negative value is narrow for ADD but not for AND. A design that picked the wrong test would zero-extend a negative sum, or sign-extend a bitwise result, and lose the upper bits. Additions that just cross the 16-bit signed boundary are driven to force the reissue path. A design that skipped it would return a sign-extended wrapped value. A design that kept sampling inputs while busy would emit a result for the op that should have been dropped. Packed lanes are driven with an all-ones plus one in the lower lane and garbage in the unused operand upper halves. Carry leaking across the lane boundary, or use of the wrong operand halves, shows up as a corrupted upper lane.

// File: rtl/nga_pkg.sv
package nga_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SLT  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    // Operations that invert B and inject a carry into the lane adder
    function automatic logic uses_sub(input logic [2:0] op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    // Bitwise operations are narrow under the zero-extension test
    function automatic logic is_bitwise(input logic [2:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_addsub(input logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/nga_sig.sv
// Significance detector: reports whether a value fits in K bits
module nga_sig #(
    parameter int unsigned W = 32,
    parameter int unsigned K = 16
) (
    input  logic [W-1:0] v,
    output logic         sx_fit,
    output logic         zx_fit
);
    always_comb begin
        sx_fit = (&v[W-1:K-1]) | ~(|v[W-1:K-1]);
        zx_fit = ~(|v[W-1:K]);
    end
endmodule

// File: rtl/nga_lane.sv
// One lane of the datapath: adder with carry in/out plus bitwise and compare
module nga_lane
    import nga_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W-1:0] bx;
    logic [W-1:0] sum;
    logic         lt;

    always_comb begin
        bx          = b ^ {W{uses_sub(op)}};
        {cout, sum} = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
        lt          = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
        case (op)
            OP_ADD, OP_SUB: res = sum;
            OP_AND:         res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_SLT:         res = {{(W-1){1'b0}}, lt};
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/narrow_gate_alu.sv
module narrow_gate_alu
    import nga_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          opcode,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic                pack_en,
    input  logic [2:0]          pk_opcode,
    input  logic [DATA_W/2-1:0] pk_a,
    input  logic [DATA_W/2-1:0] pk_b,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                narrow,
    output logic                upper_en,
    output logic                busy
);
    localparam int unsigned L = DATA_W / 2;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              nar;
        logic              upen;
        logic              busy;
        logic [DATA_W-1:0] ra;
        logic [DATA_W-1:0] rb;
        logic [2:0]        rop;
        logic [L-1:0]      ha;
        logic [L-1:0]      hb;
        logic [2:0]        hop;
    } state_t;

    state_t q, d;

    // ---------------- significance detection ----------------
    logic [1:0][DATA_W-1:0] opnd;
    logic [1:0]             sx_fit, zx_fit;

    assign opnd = {op_b, op_a};

    for (genvar i = 0; i < 2; i++) begin : g_sig
        nga_sig #(.W(DATA_W), .K(L)) u_sig (
            .v      (opnd[i]),
            .sx_fit (sx_fit[i]),
            .zx_fit (zx_fit[i])
        );
    end

    // ---------------- lane steering ----------------
    logic         accept, fits, go_pack, go_nar, go_full, hi_act, hi_chain;
    logic [L-1:0] lo_a, lo_b, lo_res, hi_a, hi_b, hi_res;
    logic [2:0]   lo_op, hi_op;
    logic         lo_cin, lo_cout, hi_cin, hi_cout, lo_ovf;

    always_comb begin
        accept  = in_valid & ~q.busy;
        fits    = is_bitwise(opcode) ? (&zx_fit) : (&sx_fit);
        go_pack = accept & pack_en;
        go_nar  = accept & ~pack_en & fits;
        go_full = accept & ~pack_en & ~fits;
        hi_act  = q.busy | go_pack | go_full;

        lo_a    = q.busy ? q.ra[L-1:0] : op_a[L-1:0];
        lo_b    = q.busy ? q.rb[L-1:0] : op_b[L-1:0];
        lo_op   = q.busy ? q.rop       : opcode;
        lo_cin  = uses_sub(lo_op);

        if (q.busy) begin
            hi_a = q.ra[DATA_W-1:L]; hi_b = q.rb[DATA_W-1:L]; hi_op = q.rop;     hi_chain = 1'b1;
        end else if (go_pack) begin
            hi_a = pk_a;             hi_b = pk_b;             hi_op = pk_opcode; hi_chain = 1'b0;
        end else if (go_full) begin
            hi_a = op_a[DATA_W-1:L]; hi_b = op_b[DATA_W-1:L]; hi_op = opcode;    hi_chain = 1'b1;
        end else begin
            // gated: upper lane sees its last operands, nothing toggles
            hi_a = q.ha;             hi_b = q.hb;             hi_op = q.hop;     hi_chain = 1'b0;
        end
    end

    assign hi_cin = hi_chain ? lo_cout : uses_sub(hi_op);

    nga_lane #(.W(L)) u_lane_lo (
        .a (lo_a), .b (lo_b), .op (lo_op), .cin (lo_cin),
        .res (lo_res), .cout (lo_cout)
    );

    nga_lane #(.W(L)) u_lane_hi (
        .a (hi_a), .b (hi_b), .op (hi_op), .cin (hi_cin),
        .res (hi_res), .cout (hi_cout)
    );

    // signed overflow of the lower lane sum
    assign lo_ovf = (lo_a[L-1] == (lo_b[L-1] ^ uses_sub(lo_op))) && (lo_res[L-1] != lo_a[L-1]);

    // ---------------- next state ----------------
    logic [DATA_W-1:0] full_res, nar_res;

    always_comb begin
        full_res = (lo_op == OP_SLT) ? {{(DATA_W-1){1'b0}}, hi_res[0]} : {hi_res, lo_res};
        nar_res  = is_addsub(lo_op) ? {{L{lo_res[L-1]}}, lo_res} : {{L{1'b0}}, lo_res};

        d      = q;
        d.vld  = 1'b0;
        d.nar  = 1'b0;
        d.upen = 1'b0;
        d.busy = 1'b0;

        if (hi_act) begin
            d.ha  = hi_a;
            d.hb  = hi_b;
            d.hop = hi_op;
        end

        if (q.busy || go_full) begin
            d.vld  = 1'b1;
            d.res  = full_res;
            d.upen = 1'b1;
        end else if (go_pack) begin
            d.vld  = 1'b1;
            d.res  = {hi_res, lo_res};
            d.upen = 1'b1;
        end else if (go_nar) begin
            if (is_addsub(opcode) && lo_ovf) begin
                d.busy = 1'b1;
                d.ra   = op_a;
                d.rb   = op_b;
                d.rop  = opcode;
            end else begin
                d.vld = 1'b1;
                d.nar = 1'b1;
                d.res = nar_res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.vld;
    assign result    = q.res;
    assign narrow    = q.nar;
    assign upper_en  = q.upen;
    assign busy      = q.busy;

endmodule

// Property checker attached to the ALU
module nga_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                pack_en,
    input logic [2:0]          opcode,
    input logic [DATA_W-1:0]   op_a,
    input logic                out_valid,
    input logic                narrow,
    input logic                upper_en,
    input logic                busy,
    input logic                go_full,
    input logic                hi_act,
    input logic [DATA_W/2-1:0] hi_a,
    input logic [DATA_W/2-1:0] hi_b,
    input logic [2:0]          hi_op,
    input logic                hi_cout,
    input logic [DATA_W/2-1:0] hi_res,
    input logic [DATA_W/2-1:0] lo_res
);
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> (out_valid || busy));

    // R2: carry out of a full-width add is set exactly when the sum wrapped
    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_full && opcode == 3'd0) |-> (hi_cout == ({hi_res, lo_res} < op_a)));

    p_upen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upper_en |-> (out_valid && !narrow));

    p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (out_valid && !upper_en));

    // R4: upper-lane operands do not change while the lane stays idle
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_act |=> (hi_act || ($stable(hi_a) && $stable(hi_b) && $stable(hi_op))));

    p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid);

    p_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (out_valid && upper_en && !narrow && !busy));

    p_pack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pack_en && !busy) |=> (out_valid && upper_en && !narrow));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !busy) |=> (!out_valid && !busy && !upper_en));
endmodule

bind narrow_gate_alu nga_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pack_en   (pack_en),
    .opcode    (opcode),
    .op_a      (op_a),
    .out_valid (out_valid),
    .narrow    (narrow),
    .upper_en  (upper_en),
    .busy      (busy),
    .go_full   (go_full),
    .hi_act    (hi_act),
    .hi_a      (hi_a),
    .hi_b      (hi_b),
    .hi_op     (hi_op),
    .hi_cout   (hi_cout),
    .hi_res    (hi_res),
    .lo_res    (lo_res)
);

// File: tb/narrow_gate_alu_tb.sv
`timescale 1ns/1ps
module narrow_gate_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        pack_en = 1'b0;
    logic [2:0]  pk_opcode = '0;
    logic [15:0] pk_a = '0, pk_b = '0;
    logic        out_valid, narrow, upper_en, busy;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // expected state for the cycle after the last edge
    bit          e_v = 0, e_n = 0, e_u = 0, e_b = 0;
    logic [31:0] e_r = '0, e_retry = '0;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    narrow_gate_alu u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .opcode (opcode),
        .op_a (op_a), .op_b (op_b), .pack_en (pack_en), .pk_opcode (pk_opcode),
        .pk_a (pk_a), .pk_b (pk_b), .out_valid (out_valid), .result (result),
        .narrow (narrow), .upper_en (upper_en), .busy (busy)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [15:0] m_lane(input logic [2:0] op, input logic [15:0] x, input logic [15:0] y);
        case (op)
            3'd0: return x + y;
            3'd1: return x - y;
            3'd2: return x & y;
            3'd3: return x | y;
            3'd4: return x ^ y;
            3'd5: return ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [31:0] m_full(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        case (op)
            3'd0: return x + y;
            3'd1: return x - y;
            3'd2: return x & y;
            3'd3: return x | y;
            3'd4: return x ^ y;
            3'd5: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit m_fits(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        if (op == 3'd2 || op == 3'd3 || op == 3'd4)
            return (x[31:16] == 16'h0) && (y[31:16] == 16'h0);
        return ($signed(x) >= -32768 && $signed(x) <= 32767) &&
               ($signed(y) >= -32768 && $signed(y) <= 32767);
    endfunction

    function automatic bit m_ovf16(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        int s;
        if (op != 3'd0 && op != 3'd1) return 0;
        s = (op == 3'd0) ? int'($signed(x[15:0])) + int'($signed(y[15:0]))
                         : int'($signed(x[15:0])) - int'($signed(y[15:0]));
        return (s > 32767) || (s < -32768);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(e_tag, "out_valid", {31'b0, out_valid}, {31'b0, e_v});
        chk(e_tag, "busy",      {31'b0, busy},      {31'b0, e_b});
        chk(e_tag, "upper_en",  {31'b0, upper_en},  {31'b0, e_u});
        if (e_v) begin
            chk(e_tag, "result", result, e_r);
            chk(e_tag, "narrow", {31'b0, narrow}, {31'b0, e_n});
        end
    endtask

    // one cycle: check the outputs of the previous edge, drive, predict
    task automatic step(input bit v, input bit pk, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [2:0] pop, input logic [15:0] pa,
                        input logic [15:0] pb, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; pack_en = pk; opcode = op; op_a = a; op_b = b;
        pk_opcode = pop; pk_a = pa; pk_b = pb;
        if (e_b) begin
            e_v = 1; e_b = 0; e_u = 1; e_n = 0; e_r = e_retry;   // keep the overflow tag
        end else if (v && pk) begin
            e_v = 1; e_b = 0; e_u = 1; e_n = 0;
            e_r = {m_lane(pop, pa, pb), m_lane(op, a[15:0], b[15:0])};
            e_tag = tag;
        end else if (v) begin
            e_tag = tag;
            if (m_fits(op, a, b) && m_ovf16(op, a, b)) begin
                e_v = 0; e_b = 1; e_u = 0; e_n = 0; e_retry = m_full(op, a, b);
            end else begin
                e_v = 1; e_b = 0; e_r = m_full(op, a, b);
                e_n = m_fits(op, a, b); e_u = !e_n;
            end
        end else begin
            e_v = 0; e_b = 0; e_u = 0; e_n = 0; e_tag = tag;
        end
    endtask

    task automatic op1(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
        step(1, 0, op, a, b, 3'd0, 16'h0, 16'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 3'd0, 32'h0, 32'h0, 3'd0, 16'h0, 16'h0, tag);
    endtask

    function automatic logic [31:0] rand_opnd();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 3)
            0:       return r;
            1:       return {{16{r[15]}}, r[15:0]};
            default: return {16'h0, r[15:0]};
        endcase
    endfunction

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "result in reset", result, 32'h0);
        chk("R1", "valid in reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        idle("R1");                                   // checks reset state after release

        op1(3'd0, 32'd5, 32'd7, "R2");                // narrow add -> 12
        op1(3'd0, 32'h0001_2345, 32'd3, "R4");        // wide add
        op1(3'd1, 32'hFFFF_FFFD, 32'd4, "R2");        // -3 - 4 narrow
        op1(3'd2, 32'h0000_F0F0, 32'h0000_00FF, "R4");// bitwise zero-ext narrow
        op1(3'd2, 32'hFFFF_FFF0, 32'h0000_000F, "R4");// negative small: wide for AND
        op1(3'd0, 32'hFFFF_FFF0, 32'h0000_000F, "R4");// same values narrow for ADD
        op1(3'd3, 32'h1200_0034, 32'h0056_0000, "R2");
        op1(3'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, "R2");
        op1(3'd5, 32'hFFFF_FFFB, 32'd3, "R2");        // -5 < 3 narrow
        op1(3'd5, 32'h8000_0000, 32'd1, "R2");        // wide compare
        op1(3'd5, 32'd3, 32'hFFFF_FFFB, "R2");        // 3 < -5 false
        op1(3'd6, 32'd9, 32'd9, "R3");
        op1(3'd7, 32'h1234_5678, 32'hFFFF_0000, "R3");
        op1(3'd0, 32'h0000_7000, 32'h0000_7000, "R5");// overflow reissue
        idle("R5");
        idle("R8");
        op1(3'd1, 32'hFFFF_8AD0, 32'h0000_2710, "R5");// -30000 - 10000
        op1(3'd0, 32'd1, 32'd1, "R6");                // presented while busy: dropped
        idle("R6");
        idle("R8");
        step(1, 1, 3'd0, 32'hABCD_FFFF, 32'h5A5A_0001, 3'd1, 16'h0000, 16'h0001, "R7");
        step(1, 1, 3'd5, 32'h1111_8000, 32'h2222_0001, 3'd4, 16'hF0F0, 16'h0FF0, "R7");
        step(1, 1, 3'd2, 32'hFFFF_00FF, 32'h0000_0F0F, 3'd5, 16'h0001, 16'hFFFF, "R7");
        op1(3'd0, 32'h7FFF_FFFF, 32'd1, "R2");        // back-to-back after packing
        idle("R8");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = rand_opnd();
            rb = rand_opnd();
            step(($urandom % 5) != 0, ($urandom % 5) == 0, 3'($urandom), ra, rb,
                 3'($urandom), 16'($urandom), 16'($urandom), "R2");
        end
        idle("R8");
        idle("R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule